// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Queue

This block is a small direct-mapped data cache that sits between a processor load/store port and a slower memory. Stores are never held back in the cache. Each accepted store updates the cached word when its line is resident. It is also posted into a short ordered queue, which a background drain loop retires to memory one word at a time. Lines are never dirty, so evicting a line needs no traffic back to memory.

A load that hits answers on the next cycle. A load that misses first waits until every posted store has reached memory. It then requests the whole line and refills it beat by beat, lowest word first, and answers once the last beat has arrived. The processor side stalls in two cases: a store that finds the queue full, and any request made while a miss is being serviced.

Addresses are word addresses. The low bits select a word within a line, the next bits select the line, and the rest form the tag that is compared against the stored tag and valid bit.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid and the store queue is empty: `req_ready` is 1 and `rsp_valid`, `mem_wr_valid` and `mem_rd_req` are 0. The first load to any address misses.
- R2: On a load miss the block raises `mem_rd_req` with `mem_rd_line` equal to the request address shifted right by the word-offset width, and holds both until `mem_rd_ready`. It then takes `2**OFF_W` beats on `mem_fill_valid`/`mem_fill_data` in word order 0 upward, and pulses `rsp_valid` with the requested word on the cycle after the last beat.
- R3: A load that hits pulses `rsp_valid` with the cached word on the cycle after it is accepted, and issues no line read.
- R4: Every accepted store appears exactly once on the memory write port with its own address and data, whether it hit or missed.
- R5: Queued stores leave in acceptance order, one per `mem_wr_valid`/`mem_wr_ready` handshake. Address and data are held steady while `mem_wr_ready` is low.
- R6: A store that hits updates the cached word, so a following load of that address hits and returns the new data.
- R7: A store that misses allocates no line, so a following load of that address misses.
- R8: With `WB_DEPTH` (default 4) stores queued, a further store sees `req_ready` low until an entry drains, and the queue never holds more than `WB_DEPTH` entries.
- R9: A load miss raises `mem_rd_req` only after the store queue is empty (`mem_wr_valid` low).
- R10: Two addresses with the same line index and different tags evict each other. A load of one after a load of the other misses.
- R11: Every load returns the value of the most recent store to that address, or the initial memory content if there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | One-cycle pulse carrying load data |
| rsp_rdata | output | DATA_W | Load data |
| mem_rd_req | output | 1 | Line read request |
| mem_rd_line | output | ADDR_W-OFF_W | Line address of the read |
| mem_rd_ready | input | 1 | Memory accepts the line read |
| mem_fill_valid | input | 1 | Refill beat present |
| mem_fill_data | input | DATA_W | Refill word, lowest offset first |
| mem_wr_valid | output | 1 | Queued store offered to memory |
| mem_wr_addr | output | ADDR_W | Word address of the queued store |
| mem_wr_data | output | DATA_W | Data of the queued store |
| mem_wr_ready | input | 1 | Memory accepts the offered store |

## Verification
The bench targets a load miss issued while stores are stuck in the queue. A design that fetched early would return memory's stale word and would raise the line read while stores remain queued. It fills the queue against a blocked memory to check that a fifth store stalls and is not dropped or written over an unread entry. It also pairs a store miss with a later load: a design that allocated on the store would wrongly answer that load as a hit. Same-index, different-tag load pairs show whether the tag compare works, since a design that ignored the tag would return the other line's data. Random loads and stores over a few tags, with random memory back-pressure, confirm that stores drain in order and every load returns the latest stored value.

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int OFF_W    = 2,
  parameter int WB_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_ready,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    mem_rd_req,
  output logic [ADDR_W-OFF_W-1:0] mem_rd_line,
  input  logic                    mem_rd_ready,
  input  logic                    mem_fill_valid,
  input  logic [DATA_W-1:0]       mem_fill_data,
  output logic                    mem_wr_valid,
  output logic [ADDR_W-1:0]       mem_wr_addr,
  output logic [DATA_W-1:0]       mem_wr_data,
  input  logic                    mem_wr_ready
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int PTR_W = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;
  localparam logic [PTR_W:0] WB_FULL = (PTR_W+1)'(WB_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_FETCH, S_FILL} state_t;
  state_t state;

  logic [DATA_W-1:0] data_q [LINES*WORDS];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  line_ok;

  logic [ADDR_W-1:0] q_addr [WB_DEPTH];
  logic [DATA_W-1:0] q_data [WB_DEPTH];
  logic [PTR_W-1:0]  q_rd, q_wr;
  logic [PTR_W:0]    q_cnt;

  logic [ADDR_W-1:0] miss_addr;
  logic [OFF_W-1:0]  beat;
  logic [DATA_W-1:0] picked;

  wire [OFF_W-1:0] r_off = req_addr[OFF_W-1:0];
  wire [IDX_W-1:0] r_idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] m_off = miss_addr[OFF_W-1:0];
  wire [IDX_W-1:0] m_idx = miss_addr[OFF_W +: IDX_W];

  wire hit     = line_ok[r_idx] && (tag_q[r_idx] == r_tag);
  wire q_full  = (q_cnt == WB_FULL);
  assign req_ready = (state == S_IDLE) && !(req_we && q_full);
  wire accept  = req_valid && req_ready;
  wire push    = accept && req_we;
  wire ld_acc  = accept && !req_we;
  wire pop     = mem_wr_valid && mem_wr_ready;
  wire fill_go = (state == S_FILL) && mem_fill_valid;
  wire fill_end = fill_go && (&beat);

  assign mem_wr_valid = (q_cnt != '0);
  assign mem_wr_addr  = q_addr[q_rd];
  assign mem_wr_data  = q_data[q_rd];
  assign mem_rd_req   = (state == S_FETCH);
  assign mem_rd_line  = miss_addr[ADDR_W-1:OFF_W];

  // store queue
  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[q_wr] <= req_addr;
      q_data[q_wr] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_rd  <= '0;
      q_wr  <= '0;
      q_cnt <= '0;
    end else begin
      if (push) q_wr <= (q_wr == PTR_W'(WB_DEPTH-1)) ? '0 : q_wr + 1'b1;
      if (pop)  q_rd <= (q_rd == PTR_W'(WB_DEPTH-1)) ? '0 : q_rd + 1'b1;
      case ({push, pop})
        2'b10:   q_cnt <= q_cnt + 1'b1;
        2'b01:   q_cnt <= q_cnt - 1'b1;
        default: q_cnt <= q_cnt;
      endcase
    end
  end

  // cache arrays
  always_ff @(posedge clk) begin
    if (push && hit) data_q[{r_idx, r_off}] <= req_wdata;
    if (fill_go)     data_q[{m_idx, beat}]  <= mem_fill_data;
    if (fill_end)    tag_q[m_idx] <= miss_addr[ADDR_W-1 -: TAG_W];
  end

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      line_ok   <= '0;
      beat      <= '0;
      miss_addr <= '0;
      picked    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (ld_acc) begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= data_q[{r_idx, r_off}];
          end else begin
            miss_addr <= req_addr;
            state     <= S_DRAIN;
          end
        end
        S_DRAIN: if (q_cnt == '0) state <= S_FETCH;
        S_FETCH: if (mem_rd_ready) begin
          beat  <= '0;
          state <= S_FILL;
        end
        default: if (fill_go) begin
          beat <= beat + 1'b1;
          if (beat == m_off) picked <= mem_fill_data;
          if (&beat) begin
            line_ok[m_idx] <= 1'b1;
            rsp_valid      <= 1'b1;
            rsp_rdata      <= (beat == m_off) ? mem_fill_data : picked;
            state          <= S_IDLE;
          end
        end
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= WB_FULL); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !mem_wr_ready) |=> (q_cnt == WB_FULL)); // R8
  AST_FETCH_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !mem_wr_valid); // R9
  AST_WR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R5
  AST_RD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ready) |=> (mem_rd_req && $stable(mem_rd_line))); // R2
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_acc && hit) |=> rsp_valid); // R3
  AST_STORE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> mem_wr_valid); // R4
endmodule

// File: tb/wt_cache_tb_top.sv
module wt_cache_tb_top;
  localparam int AW = 12, DW = 32, IW = 3, OW = 2, QD = 4;
  localparam int LW = AW - OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_rd_req;
  logic [LW-1:0] mem_rd_line;
  logic          mem_rd_ready = 1'b0, mem_fill_valid = 1'b0, mem_wr_ready = 1'b0;
  logic [DW-1:0] mem_fill_data = '0;
  logic          mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .OFF_W(OW), .WB_DEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_rd_req(mem_rd_req),
    .mem_rd_line(mem_rd_line), .mem_rd_ready(mem_rd_ready),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready));

  int checks = 0, errors = 0;
  logic [DW-1:0] mem_model [1<<AW];
  logic [DW-1:0] arch [1<<AW];
  logic [AW+DW-1:0] pend_q [$];
  bit   mvld [1<<IW];
  logic [AW-IW-OW-1:0] mtag [1<<IW];
  bit   wr_block = 1'b0;
  int   rd_count = 0;
  int   fill_left = 0, fill_wait = 0, fill_pos = 0;
  logic [LW-1:0] fill_line = '0;
  bit   done = 1'b0;

  task automatic chk(bit ok, string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic bit model_hit(logic [AW-1:0] a);
    return mvld[a[OW +: IW]] && (mtag[a[OW +: IW]] == a[AW-1 -: AW-IW-OW]);
  endfunction

  // memory side responder
  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      mem_model[i] = (i * 32'h01000193) ^ 32'hA5A50000;
      arch[i] = mem_model[i];
    end
    forever begin
      @(negedge clk);
      if (fill_left > 0 && fill_wait == 0) begin
        mem_fill_valid = 1'b1;
        mem_fill_data  = mem_model[{fill_line, OW'(fill_pos)}];
        fill_pos++;
        fill_left--;
      end else begin
        mem_fill_valid = 1'b0;
        if (fill_wait > 0) fill_wait--;
      end
      mem_wr_ready = !wr_block && ($urandom % 4 != 0);
      if (mem_wr_valid && mem_wr_ready) begin
        logic [AW+DW-1:0] front;
        front = (pend_q.size() > 0) ? pend_q[0] : '0;
        chk(pend_q.size() > 0 && mem_wr_addr == front[AW+DW-1:DW], "R5 addr order", mem_wr_addr, front[AW+DW-1:DW]);
        chk(pend_q.size() > 0 && mem_wr_data == front[DW-1:0], "R4 data", mem_wr_data, front[DW-1:0]);
        mem_model[mem_wr_addr] = mem_wr_data;
        if (pend_q.size() > 0) void'(pend_q.pop_front());
      end
      mem_rd_ready = 1'b0;
      if (mem_rd_req && fill_left == 0) begin
        chk(pend_q.size() == 0, "R9 fetch before drain", pend_q.size(), 0);
        mem_rd_ready = ($urandom % 2 == 0);
        if (mem_rd_ready) begin
          rd_count++;
          fill_line = mem_rd_line;
          fill_left = 1 << OW;
          fill_pos  = 0;
          fill_wait = 1 + $urandom % 3;
        end
      end
    end
  end

  task automatic wait_ready();
    int n = 0;
    #1;
    while (!req_ready && n < 2000) begin
      @(negedge clk); #1; n++;
    end
  endtask

  task automatic do_store(logic [AW-1:0] a, logic [DW-1:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    wait_ready();
    pend_q.push_back({a, d});
    arch[a] = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_load(logic [AW-1:0] a, string miss_rq, int hold);
    bit exp_hit;
    int rc0, cyc;
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    wait_ready();
    exp_hit = model_hit(a);
    rc0 = rd_count;
    @(negedge clk);
    req_valid = 1'b0;
    if (hold > 0) begin
      for (int i = 0; i < hold; i++) begin
        chk(!mem_rd_req && !rsp_valid, "R9 held miss", mem_rd_req, 0);
        @(negedge clk);
      end
      wr_block = 1'b0;
    end
    cyc = 0;
    while (!rsp_valid && cyc < 500) begin
      @(negedge clk); cyc++;
    end
    if (exp_hit) begin
      chk(cyc == 0 && hold == 0, "R3 hit latency", cyc, 0);
      chk(rd_count == rc0, "R3 no line read", rd_count, rc0);
    end else begin
      chk(cyc > 0 || hold > 0, {miss_rq, " expected miss"}, cyc, 1);
      chk(rd_count == rc0 + 1, {miss_rq, " one line read"}, rd_count, rc0 + 1);
      mvld[a[OW +: IW]] = 1'b1;
      mtag[a[OW +: IW]] = a[AW-1 -: AW-IW-OW];
    end
    chk(rsp_valid && rsp_rdata == arch[a], "R11 load data", rsp_rdata, arch[a]);
  endtask

  task automatic drain_wait();
    int n = 0;
    while ((mem_wr_valid || pend_q.size() != 0) && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < (1<<IW); i++) begin mvld[i] = 1'b0; mtag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready && !rsp_valid && !mem_wr_valid && !mem_rd_req, "R1 reset outputs",
        {req_ready, rsp_valid, mem_wr_valid, mem_rd_req}, 4'b1000);
    @(negedge clk);
    do_load(12'h010, "R1", 0);
    do_load(12'h011, "R2", 0);
    do_load(12'h013, "R2", 0);
    do_store(12'h012, 32'hCAFE0012);
    do_load(12'h012, "R6", 0);
    chk(model_hit(12'h012), "R6 stays resident", 0, 1);
    do_store(12'h200, 32'h0BAD0200);
    do_load(12'h200, "R7", 0);
    do_load(12'h090, "R10", 0);
    do_load(12'h010, "R10", 0);
    drain_wait();
    // full queue stall
    wr_block = 1'b1;
    @(negedge clk);
    for (int i = 0; i < QD; i++) do_store(12'h300 + AW'(i), 32'h51000000 + i);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 12'h310; req_wdata = 32'h5100FFFF;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!req_ready, "R8 stall when full", req_ready, 0);
      @(negedge clk);
    end
    wr_block = 1'b0;
    do_store(12'h310, 32'h5100FFFF);
    drain_wait();
    // load miss behind blocked stores
    wr_block = 1'b1;
    @(negedge clk);
    do_store(12'h344, 32'h77770344);
    do_store(12'h345, 32'h77770345);
    do_load(12'h345, "R9", 5);
    do_load(12'h344, "R3", 0);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 128);
      if ($urandom % 10 < 4) do_store(a, $urandom);
      else do_load(a, "R2", 0);
    end
    drain_wait();
    chk(pend_q.size() == 0 && !mem_wr_valid, "R4 all stores retired", pend_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule